// File: doc/BRIEF.md
# Ripple-Compensated Sawtooth PWM Modulator

This block turns a signed modulating word from a current-loop compensator into a two-state gate command for one inverter leg. A free-running sawtooth carrier counts every clock, so the comparison is made at the full clock rate rather than once per switching period. The gate goes high while the modulating word, clamped to the carrier range, is above the carrier reference.

To cancel the ripple that the unmodulated edge feeds back into the loop, the block can compare against a pre-distorted carrier instead of the linear ramp. The pre-distorted shape is computed offline and written into a 256-entry table through a write port before operation starts. The carrier's top 8 bits select the table entry. A single enable input selects either the table reference or the plain ramp.

Top module: `rc_sawtooth_pwm`

## Requirements
- R1: After reset the carrier starts at 0. While it is below `period` it rises by one each clock. When it is at or above `period`, it returns to 0 on the next clock.
- R2: `wrap` is high in exactly the cycles in which `carrier` is greater than or equal to `period`. With a steady `period` this is one cycle per carrier period.
- R3: The gate result registered at a clock edge is the comparison "clamped modulating word > reference". Both operands are taken from the inputs and carrier present before that edge.
- R4: With `comp_en` = 0, the reference is the carrier value itself.
- R5: With `comp_en` = 1, the reference is the table entry at index `carrier[CW-1:CW-8]`.
- R6: The modulating word is clamped to the range 0 to `period`+1. Any word at or below 0 holds the gate low for a whole period. In ramp mode, any word above `period` holds it high for a whole period.
- R7: `gate_hi` and `gate_lo` are never both 1. From the first clock after reset, `gate_lo` is the inverse of `gate_hi`.
- R8: A table write with `tbl_we` = 1 stores `tbl_data` at `tbl_addr`. The write takes effect at that clock edge, so a comparison made at the same edge still uses the old entry.
- R9: While reset is held, `carrier` is 0 and both gates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_in | input | CW+2 | Signed modulating word |
| period | input | CW | Last carrier count before wrap |
| comp_en | input | 1 | 1 selects the table reference, 0 the ramp |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 8 | Table write index |
| tbl_data | input | CW | Table write value |
| gate_hi | output | 1 | Upper switch command |
| gate_lo | output | 1 | Lower switch command |
| wrap | output | 1 | Carrier end-of-period strobe |
| carrier | output | CW | Current carrier count |

## Verification
A table write and a comparison can fall in the same cycle. The bench provokes this by rewriting, during operation, the entry that the running carrier is indexing at that moment. It expects the old entry to decide that cycle's gate and the new entry to decide the comparisons that follow. The carrier wrap can also coincide with a `period` change. The bench shortens the period below the current count and judges the return to 0 and the strobe against its own counter model.

// File: rtl/rc_sawtooth_pwm.sv
module rc_sawtooth_pwm #(
  parameter int CW = 12,
  parameter int IW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [CW+1:0] mod_in,
  input  logic [CW-1:0]        period,
  input  logic                 comp_en,
  input  logic                 tbl_we,
  input  logic [IW-1:0]        tbl_addr,
  input  logic [CW-1:0]        tbl_data,
  output logic                 gate_hi,
  output logic                 gate_lo,
  output logic                 wrap,
  output logic [CW-1:0]        carrier
);
  localparam int DEPTH = 1 << IW;
  localparam int MW = CW + 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] shape [DEPTH];
  logic [CW-1:0] cref;
  logic [CW:0]   msat;
  logic          hit;

  wire signed [MW-1:0] per_s = $signed({2'b00, period});

  assign wrap    = cnt >= period;
  assign carrier = cnt;
  assign cref    = comp_en ? shape[cnt[CW-1 -: IW]] : cnt;

  always_comb begin
    if (mod_in[MW-1])
      msat = '0;
    else if (mod_in > per_s)
      msat = {1'b0, period} + 1'b1;
    else
      msat = mod_in[CW:0];
  end

  assign hit = msat > {1'b0, cref};

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (wrap) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (tbl_we) shape[tbl_addr] <= tbl_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      gate_hi <= hit;
      gate_lo <= !hit;
    end
  end
endmodule

// File: rtl/rc_sawtooth_pwm_chk.sv
module rc_sawtooth_pwm_chk #(
  parameter int CW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic signed [CW+1:0] mod_in,
  input logic [CW-1:0]        period,
  input logic                 comp_en,
  input logic                 gate_hi,
  input logic                 gate_lo,
  input logic                 wrap,
  input logic [CW-1:0]        carrier
);
  p_no_overlap_r7: assert property (@(posedge clk) $onehot0({gate_hi, gate_lo}));

  p_compl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (gate_lo == !gate_hi));

  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (carrier == '0));

  p_count_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> (carrier == $past(carrier) + 1'b1));

  p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier < period) |-> !wrap);

  p_sat_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_in <= 0) |=> !gate_hi);

  p_sat_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!comp_en && mod_in > $signed({2'b00, period})) |=> gate_hi);
endmodule

bind rc_sawtooth_pwm rc_sawtooth_pwm_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mod_in(mod_in), .period(period), .comp_en(comp_en),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .wrap(wrap), .carrier(carrier)
);

// File: tb/rc_sawtooth_pwm_bench.sv
module rc_sawtooth_pwm_bench;
  localparam int CW = 12;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [CW+1:0] mod_in = '0;
  logic [CW-1:0] period = '0;
  logic comp_en = 1'b0;
  logic tbl_we = 1'b0;
  logic [IW-1:0] tbl_addr = '0;
  logic [CW-1:0] tbl_data = '0;
  logic gate_hi, gate_lo, wrap;
  logic [CW-1:0] carrier;

  always #2 clk = ~clk;

  rc_sawtooth_pwm #(.CW(CW), .IW(IW)) u_rc_sawtooth_pwm (
    .clk(clk), .rst_n(rst_n), .mod_in(mod_in), .period(period), .comp_en(comp_en),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .wrap(wrap), .carrier(carrier)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int model [256];
  int exp_cnt = 0;
  bit exp_g = 0;
  bit exp_valid = 0;
  int nm = 0, nper = 100, naddr = 0, ndata = 0;
  bit ncomp = 0, nwe = 0, nrst = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    int msat, rv;
    @(negedge clk);
    if (!rst_n) begin
      chk(carrier == 0, "R9 carrier in reset", carrier, 0);
      chk(!gate_hi && !gate_lo, "R9 gates in reset", {gate_hi, gate_lo}, 0);
    end else begin
      chk(carrier == exp_cnt, "R1 carrier", carrier, exp_cnt);
      chk(wrap == (exp_cnt >= int'(period)), "R2 wrap", wrap, exp_cnt >= int'(period));
      if (exp_valid) begin
        chk(gate_hi == exp_g, ncomp ? "R3 R5 gate" : "R3 R4 gate", gate_hi, exp_g);
        chk(gate_lo == !exp_g, "R7 complement", gate_lo, !exp_g);
      end else
        chk(!gate_hi && !gate_lo, "R7 first cycle", {gate_hi, gate_lo}, 0);
      chk(!(gate_hi && gate_lo), "R7 overlap", {gate_hi, gate_lo}, 0);
    end
    rst_n = nrst; mod_in = nm[CW+1:0]; period = nper[CW-1:0]; comp_en = ncomp;
    tbl_we = nwe; tbl_addr = naddr[IW-1:0]; tbl_data = ndata[CW-1:0];
    if (nrst) begin
      msat = (nm < 0) ? 0 : (nm > nper) ? nper + 1 : nm;
      rv = ncomp ? model[exp_cnt >> (CW - IW)] : exp_cnt;
      exp_g = msat > rv;
      exp_valid = 1;
      exp_cnt = (exp_cnt >= nper) ? 0 : exp_cnt + 1;
    end else begin
      exp_valid = 0;
      exp_cnt = 0;
    end
    if (nwe) model[naddr] = ndata;
  endtask

  initial begin
    nrst = 0; nper = 100;
    for (int i = 0; i < 256; i++) begin
      nwe = 1; naddr = i; ndata = (i * 29 + 5) % 101;
      step();
    end
    nwe = 0;
    step(); step();
    nrst = 1;
    // R4 R6: ramp reference, every modulating level held for one period
    for (int m = -3; m <= 103; m++) begin
      nm = m; ncomp = 0;
      for (int k = 0; k <= 100; k++) step();
    end
    // R5 R6: table reference swept the same way
    for (int m = -3; m <= 103; m++) begin
      nm = m; ncomp = 1;
      for (int k = 0; k <= 100; k++) step();
    end
    // R8: rewrite the entry in use while comparing
    nm = 50; ncomp = 1;
    for (int r = 0; r < 40; r++) begin
      nwe = 1; naddr = (exp_cnt >> (CW - IW)); ndata = (r * 37) % 101;
      step();
      nwe = 0;
      step(); step();
    end
    // R1 R2: shorten the period below the running count
    ncomp = 0; nm = 4;
    while (exp_cnt < 60) step();
    nper = 7;
    for (int k = 0; k < 80; k++) step();
    nper = 100;
    for (int k = 0; k < 250; k++) step();
    // R9: reset mid-run
    nrst = 0;
    step(); step(); step();
    nrst = 1;
    for (int k = 0; k < 50; k++) step();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule